// File: doc/BRIEF.md
# Channel Frame Sync Detector

This block watches a recovered serial channel-bit stream, one bit per clock, and finds the frame synchronisation word in it. The sync word is a 1, ten 0s, a 1, ten 0s, a 1 and a trailing 0. It contains two back-to-back runs of the longest length the channel code allows, so it cannot occur inside normal data. A 23-bit sliding window holds the most recent bits. When the window equals the first 23 bits of the word, the block raises a one-cycle sync strobe.

A flywheel runs alongside the matcher. A frame is 588 channel bits long. When enough syncs arrive at exactly that spacing, the block raises a guarded-sync flag. While the flag is up, matches at any other position are ignored. A sync that fails to appear at its expected position is replaced by an inserted strobe, so one damaged sync word does not drop the lock. Several misses in a row do drop it.

After every strobe, real or inserted, the block skips the trailing bit of the sync word and the merging bits. It then collects the next 14-bit channel symbol, which is the subcode symbol, and presents it with a one-cycle valid pulse. Demodulation of the symbols, de-interleaving and error correction are done by later blocks.

Top module: `chan_frame_sync`

## Requirements
- R1: Let cycle P be the cycle in which the last bit of the 23-bit pattern (1, ten 0s, 1, ten 0s, 1) is presented on `chan_bit_i`. While unguarded, `sync_o` is high for exactly cycle P+1, the cycle that carries the trailing 0.
- R2: Patterns whose zero runs are 11 or 9 bits long instead of 10 produce no strobe.
- R3: While unguarded, a match exactly FRAME_BITS (588) cycles after the previous strobe counts as on time. Any other match becomes the new reference. `guard_o` rises in the cycle after the third consecutive on-time strobe.
- R4: While guarded, a match that is not at the expected position gives no strobe and no subcode symbol. It does not move the expected position of the next sync.
- R5: While guarded, if no match occurs FRAME_BITS cycles after the previous strobe, `sync_o` is still raised in that cycle (an inserted sync).
- R6: After three consecutive inserted syncs, `guard_o` falls in the cycle after the third one.
- R7: An on-time match while guarded clears the miss count. Two misses, a real sync, then two more misses leave `guard_o` high.
- R8: For a strobe in cycle C, the bits presented in cycles C+4 to C+17 form the subcode symbol, first bit in the MSB of `sub_sym_o`. `sub_valid_o` is high for the single cycle C+18, with that value on `sub_sym_o`.
- R9: After reset, `sync_o`, `guard_o` and `sub_valid_o` are low.
- R10: While unguarded, an off-spacing match still gives a strobe and a subcode symbol. It restarts the on-time count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Channel bit clock |
| rst_i | input | 1 | Synchronous reset, active high |
| chan_bit_i | input | 1 | Recovered channel bit, one per clock |
| sync_o | output | 1 | Frame sync strobe, real or inserted |
| guard_o | output | 1 | Guarded-sync (locked) flag |
| sub_valid_o | output | 1 | One-cycle pulse when a subcode symbol is complete |
| sub_sym_o | output | SYM_BITS (14) | Subcode channel symbol, first received bit in MSB |

## Verification
The bench builds the block with its default parameters: ten-bit zero runs, 588-bit frames, 14-bit symbols, three merging bits, and three syncs to lock and three misses to unlock. With these values a run of seventeen full frames reaches every state. Those frames cover near-miss run lengths, a stray reference before lock, a stray word ignored under lock, inserted syncs, miss-count clearing, loss of lock and reacquisition from a saturated spacing counter. Each strobe's subcode is compared against the bits the bench placed at the requirement's offsets.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_GUARD = 1'b1
   } lock_state_e;

   // Sync pattern mask for a given zero-run length: bit 0 is the newest bit.
   function automatic logic [63:0] sync_mask(input int run_len);
      logic [63:0] m;
      m = '0;
      m[0]               = 1'b1;
      m[run_len + 1]     = 1'b1;
      m[2 * run_len + 2] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cfs_sync_window.sv
module cfs_sync_window #(
   parameter int RUN_ZEROS = 10
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bit_i,
   output logic hit_o
);
   localparam int          WIN  = 2 * RUN_ZEROS + 3;
   localparam logic [63:0] MASK = cfs_pkg::sync_mask(RUN_ZEROS);
   localparam logic [WIN-1:0] PAT = MASK[WIN-1:0];

   generate
      if (RUN_ZEROS < 1 || WIN > 64) begin : g_bad_run
         $error("cfs_sync_window: RUN_ZEROS out of range");
      end
   endgenerate

   logic [WIN-1:0] win_q;
   logic [WIN-1:0] eq;

   always_ff @(posedge clk_i) begin
      if (rst_i) win_q <= '0;
      else       win_q <= {win_q[WIN-2:0], bit_i};
   end

   generate
      for (genvar i = 0; i < WIN; i++) begin : g_cmp
         assign eq[i] = ~(win_q[i] ^ PAT[i]);
      end
   endgenerate

   assign hit_o = &eq;

endmodule

// File: rtl/cfs_frame_ctl.sv
module cfs_frame_ctl #(
   parameter int FRAME_BITS    = 588,
   parameter int LOCK_SYNCS    = 3,
   parameter int UNLOCK_MISSES = 3
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic hit_i,
   output logic sync_o,
   output logic guard_o
);
   import cfs_pkg::*;

   localparam int CW      = $clog2(FRAME_BITS + 2);
   localparam int LW      = $clog2(LOCK_SYNCS + 1);
   localparam int MW      = $clog2(UNLOCK_MISSES + 1);
   localparam logic [CW-1:0] GAP_MAX = CW'(FRAME_BITS + 1);
   localparam logic [CW-1:0] GAP_EXP = CW'(FRAME_BITS);
   localparam logic [LW-1:0] RUN_TOP = LW'(LOCK_SYNCS - 1);
   localparam logic [MW-1:0] MISS_TOP = MW'(UNLOCK_MISSES - 1);

   generate
      if (LOCK_SYNCS < 1 || UNLOCK_MISSES < 1) begin : g_bad_cnt
         $error("cfs_frame_ctl: lock and unlock counts must be at least 1");
      end
   endgenerate

   lock_state_e state_q;
   logic [CW-1:0] gap_q;
   logic [LW-1:0] run_q;
   logic [MW-1:0] miss_q;

   logic on_time, guarded, accept, insert;

   always_comb begin
      on_time = (gap_q == GAP_EXP);
      guarded = (state_q == ST_GUARD);
      accept  = hit_i && (on_time || !guarded);
      insert  = on_time && !hit_i && guarded;
   end

   assign sync_o  = accept | insert;
   assign guard_o = guarded;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap_q   <= '0;
         state_q <= ST_HUNT;
         run_q   <= '0;
         miss_q  <= '0;
      end else begin
         if (sync_o)                gap_q <= CW'(1);
         else if (gap_q != GAP_MAX) gap_q <= gap_q + CW'(1);

         unique case (state_q)
            ST_HUNT: begin
               if (hit_i && on_time) begin
                  if (run_q == RUN_TOP) begin
                     state_q <= ST_GUARD;
                     run_q   <= '0;
                     miss_q  <= '0;
                  end else begin
                     run_q <= run_q + LW'(1);
                  end
               end else if (hit_i || on_time) begin
                  run_q <= '0;
               end
            end
            ST_GUARD: begin
               if (hit_i && on_time) begin
                  miss_q <= '0;
               end else if (on_time) begin
                  if (miss_q == MISS_TOP) begin
                     state_q <= ST_HUNT;
                     miss_q  <= '0;
                     run_q   <= '0;
                  end else begin
                     miss_q <= miss_q + MW'(1);
                  end
               end
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/cfs_sym_capture.sv
module cfs_sym_capture #(
   parameter int SYM_BITS   = 14,
   parameter int MERGE_BITS = 3
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                bit_i,
   input  logic                sync_i,
   output logic                valid_o,
   output logic [SYM_BITS-1:0] sym_o
);
   localparam int FIRST = MERGE_BITS + 1;
   localparam int LAST  = FIRST + SYM_BITS - 1;
   localparam int PW    = $clog2(LAST + 2);
   localparam logic [PW-1:0] P_FIRST = PW'(FIRST);
   localparam logic [PW-1:0] P_LAST  = PW'(LAST);

   generate
      if (SYM_BITS < 2) begin : g_bad_sym
         $error("cfs_sym_capture: SYM_BITS must be at least 2");
      end
   endgenerate

   logic [PW-1:0]       pos_q;
   logic [SYM_BITS-1:0] sym_q;
   logic                valid_q;
   logic                in_field;

   assign in_field = (pos_q >= P_FIRST) && (pos_q <= P_LAST);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pos_q   <= '0;
         sym_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= (pos_q == P_LAST);
         if (in_field) sym_q <= {sym_q[SYM_BITS-2:0], bit_i};
         if (sync_i)                pos_q <= PW'(1);
         else if (pos_q == P_LAST)  pos_q <= '0;
         else if (pos_q != '0)      pos_q <= pos_q + PW'(1);
      end
   end

   assign valid_o = valid_q;
   assign sym_o   = sym_q;

endmodule

// File: rtl/chan_frame_sync.sv
module chan_frame_sync #(
   parameter int RUN_ZEROS     = 10,
   parameter int FRAME_BITS    = 588,
   parameter int SYM_BITS      = 14,
   parameter int MERGE_BITS    = 3,
   parameter int LOCK_SYNCS    = 3,
   parameter int UNLOCK_MISSES = 3
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                chan_bit_i,
   output logic                sync_o,
   output logic                guard_o,
   output logic                sub_valid_o,
   output logic [SYM_BITS-1:0] sub_sym_o
);
   localparam int SYNC_LEN = 2 * RUN_ZEROS + 4;
   localparam int MIN_FRAME = SYNC_LEN + MERGE_BITS + SYM_BITS;

   generate
      if (FRAME_BITS < MIN_FRAME) begin : g_bad_frame
         $error("chan_frame_sync: frame too short for sync and subcode symbol");
      end
   endgenerate

   logic hit;

   cfs_sync_window #(
      .RUN_ZEROS(RUN_ZEROS)
   ) u_win (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .bit_i (chan_bit_i),
      .hit_o (hit)
   );

   cfs_frame_ctl #(
      .FRAME_BITS   (FRAME_BITS),
      .LOCK_SYNCS   (LOCK_SYNCS),
      .UNLOCK_MISSES(UNLOCK_MISSES)
   ) u_ctl (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .hit_i  (hit),
      .sync_o (sync_o),
      .guard_o(guard_o)
   );

   cfs_sym_capture #(
      .SYM_BITS  (SYM_BITS),
      .MERGE_BITS(MERGE_BITS)
   ) u_sub (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .bit_i  (chan_bit_i),
      .sync_i (sync_o),
      .valid_o(sub_valid_o),
      .sym_o  (sub_sym_o)
   );

endmodule

// File: rtl/chan_frame_sync_chk.sv
module chan_frame_sync_chk #(
   parameter int FRAME_BITS = 588
) (
   input logic clk_i,
   input logic rst_i,
   input logic sync_o,
   input logic guard_o,
   input logic sub_valid_o
);
   localparam int CW = $clog2(FRAME_BITS + 2);
   localparam logic [CW-1:0] SPAN = CW'(FRAME_BITS);
   localparam logic [CW-1:0] TOP  = CW'(FRAME_BITS + 1);

   logic [CW-1:0] since_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)                since_q <= '0;
      else if (sync_o)          since_q <= CW'(1);
      else if (since_q != TOP)  since_q <= since_q + CW'(1);
   end

   // R3: the flag only comes up right after a strobe
   assert_guard_rise_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(guard_o) |-> $past(sync_o));

   // R6: the flag only drops right after an (inserted) strobe
   assert_guard_fall_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(guard_o) |-> $past(sync_o));

   // R4: under lock every strobe keeps the frame spacing
   assert_guard_spacing_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (sync_o && guard_o) |-> (since_q == SPAN));

   // R5: under lock the expected slot always carries a strobe
   assert_no_gap_while_guarded_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (guard_o && since_q == SPAN) |-> sync_o);

   // R8: the subcode valid is a single-cycle pulse
   assert_sub_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      sub_valid_o |=> !sub_valid_o);

endmodule

bind chan_frame_sync chan_frame_sync_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .sync_o     (sync_o),
   .guard_o    (guard_o),
   .sub_valid_o(sub_valid_o)
);

// File: tb/tb_chan_frame_sync.sv
module tb_chan_frame_sync;
   localparam int FB = 588;
   localparam int SB = 14;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_i = 1'b0;
   logic sync_o, guard_o, sub_valid_o;
   logic [SB-1:0] sub_sym_o;

   chan_frame_sync dut (
      .clk_i      (clk),
      .rst_i      (rst),
      .chan_bit_i (bit_i),
      .sync_o     (sync_o),
      .guard_o    (guard_o),
      .sub_valid_o(sub_valid_o),
      .sub_sym_o  (sub_sym_o)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   bit running = 1'b0;
   bit done = 1'b0;
   string tag = "R9";

   int          q_sync[$];
   string       q_stag[$];
   int          q_subc[$];
   logic [SB-1:0] q_subv[$];
   int          q_lockc[$];
   logic        q_lockv[$];
   logic        exp_lock = 1'b0;

   logic [FB-1:0] fr;

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", t, cyc, act, exp);
      end
   endtask

   task automatic put_word(input int at, input int z1, input int z2);
      fr[at] = 1'b1;
      for (int i = 1; i <= z1; i++) fr[at + i] = 1'b0;
      fr[at + z1 + 1] = 1'b1;
      for (int i = 1; i <= z2; i++) fr[at + z1 + 1 + i] = 1'b0;
      fr[at + z1 + z2 + 2] = 1'b1;
      fr[at + z1 + z2 + 3] = 1'b0;
   endtask

   task automatic build(input bit has_sync, input logic [SB-1:0] sub, input int stray, input bit near);
      for (int j = 0; j < FB; j++) fr[j] = (j % 3 == 0);
      if (has_sync) put_word(0, 10, 10);
      for (int i = 0; i < SB; i++) fr[27 + i] = sub[SB-1-i];
      if (stray >= 0) put_word(stray, 10, 10);
      if (near) begin
         put_word(100, 11, 10);
         put_word(300, 9, 10);
      end
   endtask

   // Driver: presents the frame; pushes the expected strobe, subcode and flag events
   task automatic play(input int s0, input int s1, input int lock_at, input logic lock_v);
      for (int o = 0; o < FB; o++) begin
         @(posedge clk);
         #1;
         bit_i = fr[o];
         if (o == s0 || o == s1) begin
            logic [SB-1:0] v;
            for (int i = 0; i < SB; i++) v[SB-1-i] = fr[o + 4 + i];
            q_sync.push_back(cyc);
            q_stag.push_back(tag);
            q_subc.push_back(cyc + 18);
            q_subv.push_back(v);
         end
         if (o == lock_at) begin
            q_lockc.push_back(cyc + 1);
            q_lockv.push_back(lock_v);
         end
      end
   endtask

   function automatic logic [SB-1:0] subval(input int k);
      return 14'h2000 | SB'((k * 613) & 14'h1FFF);
   endfunction

   // Monitor: compares outputs with queued expectations
   always @(negedge clk) begin
      if (running) begin
         if (q_sync.size() > 0 && q_sync[0] == cyc) begin
            chk(sync_o == 1'b1, {q_stag[0], " strobe (R1)"}, int'(sync_o), 1);
            void'(q_sync.pop_front());
            void'(q_stag.pop_front());
         end else if (sync_o) begin
            chk(1'b0, {tag, " unexpected strobe (R2)"}, 1, 0);
         end
         if (q_subc.size() > 0 && q_subc[0] == cyc) begin
            chk(sub_valid_o == 1'b1, "R8 subcode valid", int'(sub_valid_o), 1);
            chk(sub_sym_o == q_subv[0], "R8 subcode value", int'(sub_sym_o), int'(q_subv[0]));
            void'(q_subc.pop_front());
            void'(q_subv.pop_front());
         end else if (sub_valid_o) begin
            chk(1'b0, {tag, " unexpected subcode (R4)"}, 1, 0);
         end
         if (q_lockc.size() > 0 && q_lockc[0] == cyc) begin
            exp_lock = q_lockv[0];
            void'(q_lockc.pop_front());
            void'(q_lockv.pop_front());
         end
         chk(guard_o == exp_lock, {tag, " guard flag"}, int'(guard_o), int'(exp_lock));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R9: quiet outputs after reset
      chk(sync_o == 1'b0, "R9 sync", int'(sync_o), 0);
      chk(guard_o == 1'b0, "R9 guard", int'(guard_o), 0);
      chk(sub_valid_o == 1'b0, "R9 valid", int'(sub_valid_o), 0);
      running = 1'b1;

      tag = "R2";  build(0, subval(0), -1, 1);  play(-1, -1, -1, 0);
      tag = "R1";  build(1, subval(1), -1, 0);  play(23, -1, -1, 0);
      tag = "R10"; build(1, subval(2), 200, 0); play(23, 223, -1, 0);
      tag = "R10"; build(1, subval(3), -1, 0);  play(23, -1, -1, 0);
      tag = "R3";  build(1, subval(4), -1, 0);  play(23, -1, -1, 0);
      tag = "R3";  build(1, subval(5), -1, 0);  play(23, -1, -1, 0);
      tag = "R3";  build(1, subval(6), -1, 0);  play(23, -1, 23, 1);
      tag = "R4";  build(1, subval(7), 200, 0); play(23, -1, -1, 0);
      tag = "R4";  build(1, subval(8), -1, 0);  play(23, -1, -1, 0);
      tag = "R5";  build(0, subval(9), -1, 0);  play(23, -1, -1, 0);
      tag = "R5";  build(0, subval(10), -1, 0); play(23, -1, -1, 0);
      tag = "R7";  build(1, subval(11), -1, 0); play(23, -1, -1, 0);
      tag = "R7";  build(0, subval(12), -1, 0); play(23, -1, -1, 0);
      tag = "R7";  build(0, subval(13), -1, 0); play(23, -1, -1, 0);
      tag = "R6";  build(0, subval(14), -1, 0); play(23, -1, 23, 0);
      tag = "R6";  build(0, subval(15), -1, 0); play(-1, -1, -1, 0);
      tag = "R10"; build(1, subval(16), -1, 0); play(23, -1, -1, 0);

      tag = "R8";
      for (int i = 0; i < 40; i++) begin
         @(posedge clk);
         #1 bit_i = 1'b0;
      end
      @(negedge clk);
      running = 1'b0;
      chk(q_sync.size() == 0, "R1 pending strobes", q_sync.size(), 0);
      chk(q_subc.size() == 0, "R8 pending subcodes", q_subc.size(), 0);
      finish_run();
   end

endmodule